// File: doc/BRIEF.md
# Compare and Conditional Move Execution Unit

This unit executes the set-on-less-than and register-zero-conditional move operations of a 32-bit RISC pipeline. Each cycle it can accept one decoded operation: the 6-bit primary opcode, the 6-bit function code, the two source operand values, the 16-bit immediate, and the two candidate destination indices. One clock edge later it presents a write-back triple: a write enable, the destination index and the 32-bit value to write.

Compare operations always write 0 or 1. The register-register forms write to the rd index. The immediate forms write to the rt index. The immediate is always sign-extended to 32 bits first, even when the compare is unsigned. Conditional moves copy the first operand to rd, or hold the write enable low when their condition on the second operand fails. In that case the output value has no meaning.

Top module: `cmp_cmov_unit`

## Requirements
- R1: With opcode 0x00 and function 0x2a, rd receives 1 if rs_val is less than rt_val as two's-complement numbers, otherwise 0.
- R2: With opcode 0x00 and function 0x2b, rd receives 1 if rs_val is less than rt_val as unsigned numbers, otherwise 0.
- R3: Opcode 0x0a compares rs_val against the sign-extended immediate as signed numbers and writes the 0/1 result to the rt index.
- R4: Opcode 0x0b sign-extends the immediate to 32 bits, compares rs_val against it as unsigned numbers, and writes the 0/1 result to the rt index.
- R5: With rs_val = 0x00000001 and the other operand 0xffffffff, the signed register compare yields 0 and the unsigned register compare yields 1.
- R6: With opcode 0x00 and function 0x0a, rs_val is written to rd when rt_val is zero; otherwise wr_en stays low.
- R7: With opcode 0x00 and function 0x0b, rs_val is written to rd when rt_val is nonzero; otherwise wr_en stays low.
- R8: wr_en is never asserted when the selected destination index is 0.
- R9: An unrecognised opcode or function code, or issue_vld low, produces no write.
- R10: Results appear exactly one clock after the operation is presented. Reset clears wr_en, wr_idx and wr_data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_vld | input | 1 | Operation on the inputs is valid this cycle |
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function field for register-register forms |
| rs_val | input | 32 | First source operand value |
| rt_val | input | 32 | Second source operand value |
| imm | input | 16 | Immediate field |
| rt_idx | input | 5 | Destination index for immediate forms |
| rd_idx | input | 5 | Destination index for register-register forms |
| wr_en | output | 1 | Register write enable |
| wr_idx | output | 5 | Register index to write |
| wr_data | output | 32 | Value to write |

## Verification
The bench tests operand pairs that straddle the sign bit, where signed and unsigned compares disagree. A unit with the compare semantics swapped would return the inverted bit for 1 versus 0xffffffff. It also tests immediates with bit 15 set under the unsigned immediate compare. A design that zero-extended the immediate would report 0x00010000 as not below 0xffff8000. Conditional moves are exercised with the second operand zero, nonzero, and having only its top bit set, so a narrow zero test or an inverted condition shows up as a wrong wr_en. Destination index 0, swapped rd/rt selection, illegal encodings and an idle issue slot are each checked for a spurious write.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam int OPC_W = 6;
    localparam int FN_W  = 6;

    localparam logic [OPC_W-1:0] OPC_REGREG = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LTI    = 6'h0a;
    localparam logic [OPC_W-1:0] OPC_LTIU   = 6'h0b;

    localparam logic [FN_W-1:0]  FN_LT      = 6'h2a;
    localparam logic [FN_W-1:0]  FN_LTU     = 6'h2b;
    localparam logic [FN_W-1:0]  FN_MOVZ    = 6'h0a;
    localparam logic [FN_W-1:0]  FN_MOVN    = 6'h0b;

    typedef enum logic [2:0] {
        K_NONE,
        K_LT,
        K_LTU,
        K_LTI,
        K_LTIU,
        K_MOVZ,
        K_MOVN
    } op_kind_e;

endpackage

// File: rtl/cmp_decode.sv
module cmp_decode
    import cmp_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output op_kind_e         kind,
    output logic             dest_is_rt
);

    always_comb begin
        kind       = K_NONE;
        dest_is_rt = 1'b0;
        if (opcode == OPC_REGREG) begin
            case (funct)
                FN_LT:   kind = K_LT;
                FN_LTU:  kind = K_LTU;
                FN_MOVZ: kind = K_MOVZ;
                FN_MOVN: kind = K_MOVN;
                default: kind = K_NONE;
            endcase
        end else if (opcode == OPC_LTI) begin
            kind       = K_LTI;
            dest_is_rt = 1'b1;
        end else if (opcode == OPC_LTIU) begin
            kind       = K_LTIU;
            dest_is_rt = 1'b1;
        end
    end

endmodule

// File: rtl/cmp_lt.sv
module cmp_lt #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         signed_mode,
    output logic         lt
);

    localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] flip;
    logic [W-1:0] a_biased;
    logic [W-1:0] b_biased;

    always_comb begin
        flip     = signed_mode ? MSB_ONLY : '0;
        a_biased = a ^ flip;
        b_biased = b ^ flip;
        lt       = (a_biased < b_biased);
    end

endmodule

// File: rtl/cmp_zero.sv
module cmp_zero #(
    parameter int W     = 32,
    parameter int CHUNK = 8
) (
    input  logic [W-1:0] v,
    output logic         is_zero
);

    localparam int NCH  = (W + CHUNK - 1) / CHUNK;
    localparam int PADW = NCH * CHUNK;

    logic [PADW-1:0] padded;
    logic [NCH-1:0]  chunk_any;

    assign padded = PADW'(v);

    for (genvar i = 0; i < NCH; i++) begin : g_chunk
        assign chunk_any[i] = |padded[i*CHUNK +: CHUNK];
    end

    assign is_zero = ~|chunk_any;

endmodule

// File: rtl/cmp_cmov_unit.sv
module cmp_cmov_unit
    import cmp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_vld,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [FN_W-1:0]   funct,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic [IDX_W-1:0]  rt_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);

    localparam int EXT_W = DATA_W - IMM_W;

    typedef struct packed {
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } wb_t;

    wb_t st_d, st_q;

    op_kind_e          kind;
    logic              dest_is_rt;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] cmp_b;
    logic              signed_mode;
    logic              lt;
    logic              rt_zero;
    logic              we_raw;

    cmp_decode u_dec (
        .opcode     (opcode),
        .funct      (funct),
        .kind       (kind),
        .dest_is_rt (dest_is_rt)
    );

    assign imm_ext     = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign cmp_b       = dest_is_rt ? imm_ext : rt_val;
    assign signed_mode = (kind == K_LT) || (kind == K_LTI);

    cmp_lt #(.W(DATA_W)) u_lt (
        .a           (rs_val),
        .b           (cmp_b),
        .signed_mode (signed_mode),
        .lt          (lt)
    );

    cmp_zero #(.W(DATA_W)) u_zero (
        .v       (rt_val),
        .is_zero (rt_zero)
    );

    always_comb begin
        st_d   = '0;
        we_raw = 1'b0;
        case (kind)
            K_LT, K_LTU, K_LTI, K_LTIU: begin
                we_raw    = 1'b1;
                st_d.data = DATA_W'(lt);
            end
            K_MOVZ: begin
                we_raw    = rt_zero;
                st_d.data = rs_val;
            end
            K_MOVN: begin
                we_raw    = !rt_zero;
                st_d.data = rs_val;
            end
            default: begin
                we_raw    = 1'b0;
                st_d.data = '0;
            end
        endcase
        st_d.idx = dest_is_rt ? rt_idx : rd_idx;
        st_d.we  = issue_vld && we_raw && (st_d.idx != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en   = st_q.we;
    assign wr_idx  = st_q.idx;
    assign wr_data = st_q.data;

endmodule

// File: rtl/cmp_cmov_chk.sv
module cmp_cmov_chk
    import cmp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_vld,
    input logic [OPC_W-1:0]  opcode,
    input logic [FN_W-1:0]   funct,
    input logic [DATA_W-1:0] rs_val,
    input logic [DATA_W-1:0] rt_val,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data
);

    logic is_cmp_in;
    logic is_movz_in;
    logic is_movn_in;

    assign is_cmp_in  = (opcode == OPC_LTI) || (opcode == OPC_LTIU) ||
                        ((opcode == OPC_REGREG) && ((funct == FN_LT) || (funct == FN_LTU)));
    assign is_movz_in = (opcode == OPC_REGREG) && (funct == FN_MOVZ);
    assign is_movn_in = (opcode == OPC_REGREG) && (funct == FN_MOVN);

    // R8
    wr_idx_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx != '0));

    // R1
    cmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue_vld && is_cmp_in) && wr_en) |-> (wr_data[DATA_W-1:1] == '0));

    // R6
    movz_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue_vld && is_movz_in && (rt_val != '0))) |-> !wr_en);

    // R7
    movn_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue_vld && is_movn_in) && wr_en) |-> (wr_data == $past(rs_val)));

    // R9
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(issue_vld)) |-> !wr_en);

endmodule

bind cmp_cmov_unit cmp_cmov_chk #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_vld (issue_vld),
    .opcode    (opcode),
    .funct     (funct),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
);

// File: tb/sim_cmp_cmov_unit.sv
`timescale 1ns/1ps
module sim_cmp_cmov_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_vld = 1'b0;
    logic [5:0]  opcode = '0;
    logic [5:0]  funct = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [15:0] imm = '0;
    logic [4:0]  rt_idx = '0;
    logic [4:0]  rd_idx = '0;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmp_cmov_unit u0 (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld),
        .opcode(opcode), .funct(funct), .rs_val(rs_val), .rt_val(rt_val),
        .imm(imm), .rt_idx(rt_idx), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    task automatic expect_wb(input string tag, input logic we_e,
                             input logic [4:0] idx_e, input logic [31:0] data_e);
        checks++;
        if (wr_en !== we_e || (we_e && (wr_idx !== idx_e || wr_data !== data_e))) begin
            errors++;
            $display("FAIL %s: got we=%0b idx=%0d data=%h, expected we=%0b idx=%0d data=%h",
                     tag, wr_en, wr_idx, wr_data, we_e, idx_e, data_e);
        end
    endtask

    // drive at a falling edge, one rising edge passes, sample at next falling edge
    task automatic issue(input logic v, input logic [5:0] op, input logic [5:0] fn,
                         input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                         input logic [4:0] ti, input logic [4:0] di);
        issue_vld = v; opcode = op; funct = fn; rs_val = a; rt_val = b;
        imm = im; rt_idx = ti; rd_idx = di;
        @(negedge clk);
        issue_vld = 1'b0;
    endtask

    task automatic t_reset();
        expect_wb("R10 reset we", 1'b0, 5'd0, 32'd0);
        checks++;
        if (wr_idx !== 5'd0 || wr_data !== 32'd0) begin
            errors++;
            $display("FAIL R10 reset outputs: idx=%0d data=%h expected 0/0", wr_idx, wr_data);
        end
    endtask

    task automatic t_slt();
        issue(1, 6'h00, 6'h2a, 32'hFFFFFFFB, 32'd3, 16'h0, 5'd4, 5'd7);
        expect_wb("R1 -5<3", 1, 5'd7, 32'd1);
        issue(1, 6'h00, 6'h2a, 32'd7, 32'd7, 16'h0, 5'd4, 5'd8);
        expect_wb("R1 equal", 1, 5'd8, 32'd0);
        issue(1, 6'h00, 6'h2a, 32'h7FFFFFFF, 32'h80000000, 16'h0, 5'd4, 5'd9);
        expect_wb("R1 max vs min", 1, 5'd9, 32'd0);
    endtask

    task automatic t_sltu();
        issue(1, 6'h00, 6'h2b, 32'd3, 32'hFFFFFFFB, 16'h0, 5'd4, 5'd10);
        expect_wb("R2 3<big", 1, 5'd10, 32'd1);
        issue(1, 6'h00, 6'h2b, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd4, 5'd11);
        expect_wb("R2 msb set", 1, 5'd11, 32'd0);
        issue(1, 6'h00, 6'h2b, 32'h1234, 32'h1234, 16'h0, 5'd4, 5'd12);
        expect_wb("R2 equal", 1, 5'd12, 32'd0);
    endtask

    task automatic t_slti();
        issue(1, 6'h0a, 6'h00, 32'hFFFFFFFE, 32'h0, 16'hFFFF, 5'd13, 5'd1);
        expect_wb("R3 -2<-1", 1, 5'd13, 32'd1);
        issue(1, 6'h0a, 6'h00, 32'd5, 32'h0, 16'h0005, 5'd14, 5'd1);
        expect_wb("R3 equal", 1, 5'd14, 32'd0);
        issue(1, 6'h0a, 6'h00, 32'd0, 32'h0, 16'h8000, 5'd15, 5'd1);
        expect_wb("R3 0 vs -32768", 1, 5'd15, 32'd0);
    endtask

    task automatic t_sltiu();
        issue(1, 6'h0b, 6'h00, 32'h00010000, 32'h0, 16'h8000, 5'd16, 5'd1);
        expect_wb("R4 sext imm unsigned", 1, 5'd16, 32'd1);
        issue(1, 6'h0b, 6'h00, 32'hFFFFFFF0, 32'h0, 16'hFFFF, 5'd17, 5'd1);
        expect_wb("R4 vs all-ones", 1, 5'd17, 32'd1);
        issue(1, 6'h0b, 6'h00, 32'd5, 32'h0, 16'h0003, 5'd18, 5'd1);
        expect_wb("R4 5 vs 3", 1, 5'd18, 32'd0);
    endtask

    task automatic t_boundary();
        issue(1, 6'h00, 6'h2a, 32'd1, 32'hFFFFFFFF, 16'h0, 5'd2, 5'd19);
        expect_wb("R5 signed 1 vs -1", 1, 5'd19, 32'd0);
        issue(1, 6'h00, 6'h2b, 32'd1, 32'hFFFFFFFF, 16'h0, 5'd2, 5'd20);
        expect_wb("R5 unsigned 1 vs ffffffff", 1, 5'd20, 32'd1);
    endtask

    task automatic t_movz();
        issue(1, 6'h00, 6'h0a, 32'hDEADBEEF, 32'd0, 16'h0, 5'd3, 5'd21);
        expect_wb("R6 rt zero moves", 1, 5'd21, 32'hDEADBEEF);
        issue(1, 6'h00, 6'h0a, 32'hDEADBEEF, 32'd1, 16'h0, 5'd3, 5'd21);
        expect_wb("R6 rt nonzero blocks", 0, 5'd0, 32'd0);
        issue(1, 6'h00, 6'h0a, 32'h0BADF00D, 32'h80000000, 16'h0, 5'd3, 5'd21);
        expect_wb("R6 rt msb only blocks", 0, 5'd0, 32'd0);
    endtask

    task automatic t_movn();
        issue(1, 6'h00, 6'h0b, 32'hCAFEF00D, 32'h80000000, 16'h0, 5'd3, 5'd22);
        expect_wb("R7 rt msb only moves", 1, 5'd22, 32'hCAFEF00D);
        issue(1, 6'h00, 6'h0b, 32'hCAFEF00D, 32'd0, 16'h0, 5'd3, 5'd22);
        expect_wb("R7 rt zero blocks", 0, 5'd0, 32'd0);
    endtask

    task automatic t_zero_dest();
        issue(1, 6'h00, 6'h2a, 32'hFFFFFFFF, 32'd1, 16'h0, 5'd5, 5'd0);
        expect_wb("R8 rd zero", 0, 5'd0, 32'd0);
        issue(1, 6'h0a, 6'h00, 32'hFFFFFFFF, 32'd0, 16'h0001, 5'd0, 5'd6);
        expect_wb("R8 rt zero on imm form", 0, 5'd0, 32'd0);
        issue(1, 6'h0a, 6'h00, 32'hFFFFFFFF, 32'd0, 16'h0001, 5'd9, 5'd0);
        expect_wb("R3 imm form ignores rd", 1, 5'd9, 32'd1);
        issue(1, 6'h00, 6'h0a, 32'h55, 32'd0, 16'h0, 5'd23, 5'd0);
        expect_wb("R8 move to index 0", 0, 5'd0, 32'd0);
    endtask

    task automatic t_illegal();
        issue(1, 6'h00, 6'h20, 32'd1, 32'd2, 16'h0, 5'd3, 5'd24);
        expect_wb("R9 bad funct", 0, 5'd0, 32'd0);
        issue(1, 6'h23, 6'h2a, 32'd1, 32'd2, 16'h0, 5'd3, 5'd24);
        expect_wb("R9 bad opcode", 0, 5'd0, 32'd0);
        issue(0, 6'h00, 6'h2a, 32'hFFFFFFFF, 32'd2, 16'h0, 5'd3, 5'd24);
        expect_wb("R9 not valid", 0, 5'd0, 32'd0);
    endtask

    task automatic t_latency();
        issue(1, 6'h00, 6'h2b, 32'd0, 32'd9, 16'h0, 5'd3, 5'd25);
        expect_wb("R10 one-cycle result", 1, 5'd25, 32'd1);
        @(negedge clk);
        expect_wb("R10 idle after op", 0, 5'd0, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_slt();
        t_sltu();
        t_slti();
        t_sltiu();
        t_boundary();
        t_movz();
        t_movn();
        t_zero_dest();
        t_illegal();
        t_latency();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule